// File: doc/BRIEF.md
# Single-Channel Byte DMA with Address-Decoded Request Selection

This block is one DMA channel that copies bytes between memory and an I/O port, or between memory and a location in memory space that acts as I/O. Software loads a 20-bit source address, a 20-bit destination address, a 16-bit byte count and a mode word. It then sets the channel enable. Each byte is moved with one read cycle followed at once by one write cycle on a simple byte bus. The bus carries a memory/I/O space select. The source and destination addresses are stepped independently after every byte.

The channel waits for a request before each byte. The request comes either from an external pin or from an on-chip serial port's transmit-empty or receive-full flag. The choice is made by decoding the address of whichever side is set to I/O space. The external pin passes through a two-flop synchronizer and is sensed either on its rising edge or by its level. The enable bit is protected: a write to the control register changes it only when a companion inhibit bit in the same write is 0. When the count runs out, the channel drops its enable, pulses a transfer-end output on the last write and sets a sticky end flag. If interrupts are enabled, that flag raises the interrupt output.

Top module: `dma_chan`

Register selects on `reg_sel`: 0 source address, 1 destination address, 2 byte count, 3 mode, 4 control.

## Requirements
- R1: The first read of a transfer is at the programmed source address and the first write is at the programmed destination address.
- R2: Each side's 2-bit address mode is defined as follows. Code 00 adds one after every byte and 01 subtracts one. Code 10 holds the address fixed in memory space. Code 11 holds it fixed in I/O space, with bus_io high and the bus address bits 19..16 driven to 0. The source mode sits in mode bits 1..0 and the destination mode in bits 3..2.
- R3: A transfer with a count of N (1 to 65535) moves exactly N bytes and then stops.
- R4: Every byte is one cycle with bus_rd high followed immediately by one cycle with bus_wr high, and the write data equals the byte read. The two strobes are never high together.
- R5: With mode bit 4 set to 1 (edge sensing), each rising edge of ext_req moves exactly one byte, however long the pin stays high.
- R6: With mode bit 4 set to 0 (level sensing), bytes keep moving while ext_req is high and stop once it has been low long enough to pass the synchronizer.
- R7: A write to the control register loads its bit 0 into the enable only if its bit 1 is 0. With bit 1 set to 1, the enable keeps its value.
- R8: The write cycle of the last byte has tend high. It is the only cycle of the transfer with tend high. After that cycle chan_en reads 0.
- R9: irq is high while the end flag is set and mode bit 5 is 1. Writing the byte count clears the end flag.
- R10: When one side is in I/O space, address bits 16, 17 and 19 of that side must all be 0 for ext_req to be honoured; otherwise no byte moves. Bit 18 is ignored. When both sides are in I/O space, the destination side is decoded.
- R11: When the decoded I/O address bits 15..4 equal the serial page (default 0x00C), ext_req is ignored. The request is then ser_tx_empty if the destination is the I/O side, or ser_rx_full if only the source is.
- R12: req_pin_oe equals mode bit 6 while the channel is disabled, and is 0 while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 20 | Register write data |
| ext_req | input | 1 | External request pin (asynchronous) |
| ser_tx_empty | input | 1 | Serial port transmit register empty |
| ser_rx_full | input | 1 | Serial port receive register full |
| bus_addr | output | 20 | Bus address |
| bus_io | output | 1 | 1 = I/O space cycle, 0 = memory space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled at the end of the read cycle |
| tend | output | 1 | High during the final write of a transfer |
| irq | output | 1 | Termination interrupt |
| chan_en | output | 1 | Channel enable state |
| req_pin_oe | output | 1 | Drive enable of the shared request pin |

## Verification
The hardest case to reach is a channel that is enabled and has count left, yet must stay still. This happens when the decoded I/O address has a forbidden upper bit set, or when the serial flags gate the request while the external pin is held high. The bench holds ext_req high throughout those cases. It programs each blocked address, waits far longer than a byte takes, and checks both the write count and the enable. It then flips only the serial flag or the address bit to show that the same setup does move bytes. The address modes are swept over all sixteen source/destination pairs. Every bus address and data byte is compared against arithmetic expectations.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        AM_INC     = 2'b00,
        AM_DEC     = 2'b01,
        AM_FIX_MEM = 2'b10,
        AM_FIX_IO  = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } xfer_state_e;

    // mode word: [1:0] source mode, [3:2] destination mode,
    // [4] edge sense, [5] interrupt enable, [6] request pin as output
    typedef struct packed {
        logic       pin_out;
        logic       int_en;
        logic       edge_sense;
        addr_mode_e dst;
        addr_mode_e src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam logic [2:0] RSEL_SRC  = 3'd0;
    localparam logic [2:0] RSEL_DST  = 3'd1;
    localparam logic [2:0] RSEL_CNT  = 3'd2;
    localparam logic [2:0] RSEL_MODE = 3'd3;
    localparam logic [2:0] RSEL_CTL  = 3'd4;

    localparam int CTL_EN  = 0;
    localparam int CTL_INH = 1;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_pkg::*;
#(
    parameter int AW = 20
) (
    input  addr_mode_e      mode,
    input  logic [AW-1:0]   cur,
    output logic [AW-1:0]   nxt
);

    always_comb begin
        unique case (mode)
            AM_INC:  nxt = cur + AW'(1);
            AM_DEC:  nxt = cur - AW'(1);
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dma_req_sel.sv
// Request source selection. The address width must equal IOW + 4.
module dma_req_sel
    import dma_pkg::*;
#(
    parameter int AW      = 20,
    parameter int IOW     = 16,
    parameter int SER_LSB = 4,
    parameter logic [IOW-SER_LSB-1:0] SER_PAGE = 'h00C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_req,
    input  logic          edge_sense,
    input  logic          armed,
    input  logic          take,
    input  addr_mode_e    src_mode,
    input  addr_mode_e    dst_mode,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic          tx_empty,
    input  logic          rx_full,
    output logic          req
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic pend;
    } sync_t;

    sync_t q, d;

    logic          dst_io, src_io, any_io, ser_hit, ext_ok, rise, ext_now;
    logic [AW-1:0] io_addr;
    logic          unused_bits;

    always_comb begin
        dst_io  = (dst_mode == AM_FIX_IO);
        src_io  = (src_mode == AM_FIX_IO);
        any_io  = dst_io | src_io;
        io_addr = dst_io ? dst_addr : src_addr;
        ser_hit = any_io && (io_addr[IOW-1:SER_LSB] == SER_PAGE);
        ext_ok  = !any_io || !(io_addr[IOW] | io_addr[IOW+1] | io_addr[IOW+3]);
        rise    = q.s2 & ~q.s3;
        ext_now = edge_sense ? q.pend : q.s2;

        d      = q;
        d.s1   = ext_req;
        d.s2   = q.s1;
        d.s3   = q.s2;
        if (!armed)     d.pend = 1'b0;
        else if (take)  d.pend = rise;
        else            d.pend = q.pend | rise;

        if (!armed)       req = 1'b0;
        else if (ser_hit) req = dst_io ? tx_empty : rx_full;
        else              req = ext_ok & ext_now;
    end

    assign unused_bits = ^{io_addr[SER_LSB-1:0], io_addr[IOW+2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a consumed edge request with no fresh edge leaves nothing pending
    p_edge_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && take && !rise) |=> !q.pend);

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW      = 20,
    parameter int IOW     = 16,
    parameter int CW      = 16,
    parameter int DW      = 8,
    parameter int SER_LSB = 4,
    parameter logic [IOW-SER_LSB-1:0] SER_PAGE = 'h00C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          ext_req,
    input  logic          ser_tx_empty,
    input  logic          ser_rx_full,
    output logic [AW-1:0] bus_addr,
    output logic          bus_io,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          tend,
    output logic          irq,
    output logic          chan_en,
    output logic          req_pin_oe
);

    localparam int NSIDE = 2;
    localparam int UPW   = AW - IOW;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        mode_t         mode;
        logic          en;
        logic          eot;
        xfer_state_e   st;
        logic [DW-1:0] data;
    } chan_t;

    chan_t q, d;

    logic          req, take, last;
    logic [AW-1:0] side_cur  [NSIDE];
    addr_mode_e    side_mode [NSIDE];
    logic [AW-1:0] side_nxt  [NSIDE];

    function automatic logic [AW-1:0] bus_view(input addr_mode_e m, input logic [AW-1:0] a);
        return (m == AM_FIX_IO) ? {{UPW{1'b0}}, a[IOW-1:0]} : a;
    endfunction

    always_comb begin
        side_cur[0]  = q.src;
        side_mode[0] = q.mode.src;
        side_cur[1]  = q.dst;
        side_mode[1] = q.mode.dst;
    end

    genvar g;
    generate
        for (g = 0; g < NSIDE; g++) begin : g_side
            dma_addr_step #(.AW(AW)) u_step (
                .mode (side_mode[g]),
                .cur  (side_cur[g]),
                .nxt  (side_nxt[g])
            );
        end
    endgenerate

    dma_req_sel #(
        .AW(AW), .IOW(IOW), .SER_LSB(SER_LSB), .SER_PAGE(SER_PAGE)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req    (ext_req),
        .edge_sense (q.mode.edge_sense),
        .armed      (q.en),
        .take       (take),
        .src_mode   (q.mode.src),
        .dst_mode   (q.mode.dst),
        .src_addr   (q.src),
        .dst_addr   (q.dst),
        .tx_empty   (ser_tx_empty),
        .rx_full    (ser_rx_full),
        .req        (req)
    );

    always_comb begin
        last = (q.cnt == CW'(1));
        take = (q.st == ST_IDLE) && q.en && req;
        d    = q;

        // byte sequencer
        unique case (q.st)
            ST_IDLE: begin
                if (take) d.st = ST_READ;
            end
            ST_READ: begin
                d.data = bus_rdata;
                d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                d.src = side_nxt[0];
                d.dst = side_nxt[1];
                d.cnt = q.cnt - CW'(1);
                d.st  = ST_IDLE;
                if (last) begin
                    d.en  = 1'b0;
                    d.eot = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // software writes take priority over the sequencer
        if (reg_we) begin
            unique case (reg_sel)
                RSEL_SRC:  d.src  = reg_wdata;
                RSEL_DST:  d.dst  = reg_wdata;
                RSEL_CNT: begin
                    d.cnt = reg_wdata[CW-1:0];
                    d.eot = 1'b0;
                end
                RSEL_MODE: d.mode = mode_t'(reg_wdata[MODE_W-1:0]);
                RSEL_CTL: begin
                    if (!reg_wdata[CTL_INH]) d.en = reg_wdata[CTL_EN];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rd     = (q.st == ST_READ);
        bus_wr     = (q.st == ST_WRITE);
        bus_wdata  = q.data;
        bus_addr   = '0;
        bus_io     = 1'b0;
        if (bus_rd) begin
            bus_addr = bus_view(q.mode.src, q.src);
            bus_io   = (q.mode.src == AM_FIX_IO);
        end else if (bus_wr) begin
            bus_addr = bus_view(q.mode.dst, q.dst);
            bus_io   = (q.mode.dst == AM_FIX_IO);
        end
        tend       = bus_wr && last;
        irq        = q.eot && q.mode.int_en;
        chan_en    = q.en;
        req_pin_oe = q.mode.pin_out && !q.en;
    end

    // R4: strobes exclusive, a read is always followed by its write
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);
    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !$past(!rst_n)) |-> $past(bus_rd));
    // R2: I/O space cycles carry only a 16-bit address
    p_io_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> (bus_addr[AW-1:IOW] == '0));
    // R8: end pulse only on a write, and the channel stops after it
    p_tend_on_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> bus_wr);
    p_tend_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tend && !reg_we) |=> (!chan_en && q.eot));
    // R9: a count write clears the interrupt
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == RSEL_CNT) |=> !irq);
    // R7: inhibited control write keeps the enable
    p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == RSEL_CTL && reg_wdata[CTL_INH] && !bus_wr) |=> $stable(chan_en));
    // R12: the shared pin is never driven while the channel runs
    p_pin_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |-> !req_pin_oe);
    // R3: a disabled idle channel starts no cycle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !bus_rd && !reg_we) |=> !bus_rd);

endmodule

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [19:0] reg_wdata = '0;
    logic        ext_req = 1'b0;
    logic        ser_tx_empty = 1'b0;
    logic        ser_rx_full = 1'b0;
    logic [19:0] bus_addr;
    logic        bus_io, bus_rd, bus_wr, tend, irq, chan_en, req_pin_oe;
    logic [7:0]  bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    assign bus_rdata = mem_val(bus_addr);

    dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ext_req(ext_req), .ser_tx_empty(ser_tx_empty),
        .ser_rx_full(ser_rx_full), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tend(tend), .irq(irq), .chan_en(chan_en),
        .req_pin_oe(req_pin_oe)
    );

    int n_chk = 0;
    int n_err = 0;

    int          nrd, nwr, ntend, tend_idx, seq_err;
    logic        prev_rd;
    logic [19:0] rd_a [64];
    logic        rd_io [64];
    logic [19:0] wr_a [64];
    logic        wr_io [64];
    logic [7:0]  wr_d [64];

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic clear_log();
        nrd = 0; nwr = 0; ntend = 0; tend_idx = -1; seq_err = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd && bus_wr)    seq_err++;
            if (bus_wr && !prev_rd)  seq_err++;
            if (tend && !bus_wr)     seq_err++;
            if (bus_rd) begin
                if (nrd < 64) begin rd_a[nrd] = bus_addr; rd_io[nrd] = bus_io; end
                nrd++;
            end
            if (bus_wr) begin
                if (nwr < 64) begin
                    wr_a[nwr] = bus_addr; wr_io[nwr] = bus_io; wr_d[nwr] = bus_wdata;
                end
                if (tend) begin ntend++; tend_idx = nwr; end
                nwr++;
            end
            prev_rd = bus_rd;
        end else begin
            prev_rd = 1'b0;
        end
    end

    task automatic wreg(input logic [2:0] s, input logic [19:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        int t = 0;
        while (chan_en && t < 3000) begin @(negedge clk); t++; end
    endtask

    function automatic logic [19:0] exp_addr(input logic [19:0] b, input int m, input int k);
        case (m)
            0:       return b + 20'(k);
            1:       return b - 20'(k);
            2:       return b;
            default: return {4'h0, b[15:0]};
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [19:0] sa, da;
        int w1;
        clear_log();
        prev_rd = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);

        // reset state
        chk(!chan_en && !irq && !bus_rd && !bus_wr && !tend && !req_pin_oe, "R12 reset",
            {chan_en, irq, bus_rd, bus_wr, tend, req_pin_oe}, 0);

        // R1 R2 R3 R4 R8 R9: sweep every source/destination mode pair, level sensing
        ext_req = 1'b1;
        sa = 20'h40A50;
        da = 20'h4C3A8;
        for (int sm = 0; sm < 4; sm++) begin
            for (int dm = 0; dm < 4; dm++) begin
                int n;
                int ie;
                n  = 3 + (sm + dm) % 3;
                ie = (sm + dm) & 1;
                clear_log();
                wreg(3'd0, sa);
                wreg(3'd1, da);
                wreg(3'd2, 20'(n));
                wreg(3'd3, 20'((ie << 5) | (dm << 2) | sm));
                wreg(3'd4, 20'h1);
                wait_done();
                cycles(4);
                chk(nwr == n && nrd == n, "R3 byte count", nwr, n);
                chk(seq_err == 0, "R4 read/write sequence", seq_err, 0);
                for (int k = 0; k < n; k++) begin
                    logic [19:0] er, ew;
                    er = exp_addr(sa, sm, k);
                    ew = exp_addr(da, dm, k);
                    chk(rd_a[k] == er && rd_io[k] == (sm == 3), (k == 0) ? "R1 source addr" : "R2 source step",
                        rd_a[k], er);
                    chk(wr_a[k] == ew && wr_io[k] == (dm == 3), (k == 0) ? "R1 dest addr" : "R2 dest step",
                        wr_a[k], ew);
                    chk(wr_d[k] == mem_val(er), "R4 data copied", wr_d[k], mem_val(er));
                end
                chk(ntend == 1 && tend_idx == n - 1, "R8 tend on last write", tend_idx, n - 1);
                chk(!chan_en, "R8 enable cleared", chan_en, 0);
                chk(irq == ie[0], "R9 irq follows enable bit", irq, ie);
                if (ie == 1) begin
                    wreg(3'd2, 20'd1);
                    chk(!irq, "R9 count write clears irq", irq, 0);
                end
            end
        end
        ext_req = 1'b0;
        cycles(4);

        // R5: edge sensing, one byte per rising edge
        clear_log();
        wreg(3'd0, 20'h00100);
        wreg(3'd1, 20'h00200);
        wreg(3'd2, 20'd3);
        wreg(3'd3, 20'h10);
        wreg(3'd4, 20'h1);
        cycles(10);
        chk(nwr == 0, "R5 no edge no byte", nwr, 0);
        for (int i = 0; i < 3; i++) begin
            ext_req = 1'b1;
            cycles(20);
            chk(nwr == i + 1, "R5 one byte per edge", nwr, i + 1);
            ext_req = 1'b0;
            cycles(10);
        end
        chk(!chan_en, "R5 done after three edges", chan_en, 0);

        // R6: level sensing stops when the pin drops
        clear_log();
        wreg(3'd0, 20'h00300);
        wreg(3'd1, 20'h00400);
        wreg(3'd2, 20'd40);
        wreg(3'd3, 20'h00);
        wreg(3'd4, 20'h1);
        ext_req = 1'b1;
        cycles(12);
        ext_req = 1'b0;
        cycles(10);
        w1 = nwr;
        chk(w1 >= 2 && w1 < 40, "R6 repeats while high", w1, 2);
        cycles(30);
        chk(nwr == w1 && chan_en, "R6 stops while low", nwr, w1);
        ext_req = 1'b1;
        wait_done();
        ext_req = 1'b0;
        cycles(4);
        chk(nwr == 40, "R6 resumes to completion", nwr, 40);

        // R7: enable write protection
        wreg(3'd2, 20'd5);
        wreg(3'd4, 20'h3);
        chk(!chan_en, "R7 inhibited set ignored", chan_en, 0);
        wreg(3'd4, 20'h1);
        chk(chan_en, "R7 plain set", chan_en, 1);
        wreg(3'd4, 20'h2);
        chk(chan_en, "R7 inhibited clear ignored", chan_en, 1);
        wreg(3'd4, 20'h0);
        chk(!chan_en, "R7 plain clear", chan_en, 0);

        // R10: upper I/O address bits gate the external request
        ext_req = 1'b1;
        for (int b = 0; b < 3; b++) begin
            logic [19:0] bad;
            bad = (b == 0) ? 20'h10020 : (b == 1) ? 20'h20020 : 20'h80020;
            clear_log();
            wreg(3'd0, 20'h00500);
            wreg(3'd1, bad);
            wreg(3'd2, 20'd4);
            wreg(3'd3, 20'h0C);
            wreg(3'd4, 20'h1);
            cycles(40);
            chk(nwr == 0 && chan_en, "R10 blocked upper bit", nwr, 0);
            wreg(3'd4, 20'h0);
        end
        clear_log();
        wreg(3'd1, 20'h40020);
        wreg(3'd2, 20'd4);
        wreg(3'd4, 20'h1);
        wait_done();
        cycles(4);
        chk(nwr == 4 && wr_a[0] == 20'h00020, "R10 bit 18 ignored", nwr, 4);

        // R11: serial page uses the port flags
        clear_log();
        wreg(3'd0, 20'h00600);
        wreg(3'd1, 20'h000C3);
        wreg(3'd2, 20'd3);
        wreg(3'd3, 20'h0C);
        ser_tx_empty = 1'b0;
        ser_rx_full  = 1'b1;
        wreg(3'd4, 20'h1);
        cycles(40);
        chk(nwr == 0, "R11 external ignored, tx flag low", nwr, 0);
        ser_tx_empty = 1'b1;
        wait_done();
        cycles(4);
        chk(nwr == 3 && wr_a[2] == 20'h000C3, "R11 tx flag drives writes", nwr, 3);

        clear_log();
        ser_rx_full = 1'b0;
        wreg(3'd0, 20'h000C5);
        wreg(3'd1, 20'h00700);
        wreg(3'd2, 20'd3);
        wreg(3'd3, 20'h03);
        wreg(3'd4, 20'h1);
        cycles(40);
        chk(nwr == 0, "R11 rx flag low blocks", nwr, 0);
        ser_rx_full = 1'b1;
        wait_done();
        cycles(4);
        chk(nwr == 3 && rd_io[0] && rd_a[0] == 20'h000C5, "R11 rx flag drives reads", rd_a[0], 20'h000C5);
        ext_req = 1'b0;
        ser_tx_empty = 1'b0;
        ser_rx_full = 1'b0;

        // R12: shared pin direction
        wreg(3'd3, 20'h40);
        chk(req_pin_oe, "R12 pin output when idle", req_pin_oe, 1);
        wreg(3'd2, 20'd2);
        wreg(3'd4, 20'h1);
        chk(!req_pin_oe, "R12 pin forced input when running", req_pin_oe, 0);
        wreg(3'd4, 20'h0);
        chk(req_pin_oe, "R12 pin output after stop", req_pin_oe, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule